// File: doc/BRIEF.md
# Integer Compare to Condition Field

This unit turns an integer compare into a 4-bit condition code and writes that code into one field of an eight-field, 32-bit condition register. It decodes four compare instructions. Two compare one register operand with a second register operand. The other two compare a register operand with a 16-bit immediate. Each form comes in a signed and an unsigned flavour. The unit compares in full 64-bit width only when the core runs in 64-bit mode and the instruction's width bit is set. In every other case it first narrows both operands to their low 32 bits.

A second request path serves record-form arithmetic. An external datapath presents its result, and the unit compares that result with zero (signed) and writes the code into field 0. Explicit compares and record updates may arrive in the same cycle. When both target field 0, the explicit compare wins. The register file and the arithmetic that produces record results live outside the unit.

Top module: `ccu_top`

## Requirements
- R1: The condition register is 32 bits wide. Field k occupies bits [31-4k:28-4k], so field 0 is the most significant nibble. Inside a field, LT has weight 8, GT weight 4, EQ weight 2 and SO weight 1.
- R2: Every written field has exactly one of LT, GT and EQ set. LT means A is below B, GT means A is above B, and EQ is set otherwise.
- R3: The SO bit of each written field equals the `sumOvf` input in the cycle of the request, whatever the compare outcome.
- R4: Register-register compares use primary opcode 31 in instrWord[31:26]. Extended opcode 0 in instrWord[10:1] is the signed compare and extended opcode 32 is the unsigned compare. Both use opndB as the second operand.
- R5: Primary opcode 11 is a signed compare with instrWord[15:0] sign-extended. Primary opcode 10 is an unsigned compare with instrWord[15:0] zero-extended.
- R6: The compare is done on the full 64 bits only when `wideMode` is 1 and the width bit instrWord[21] is 1.
- R7: In all other cases both operands are reduced to their low 32 bits before comparing. They are sign-extended for signed compares and zero-extended for unsigned compares.
- R8: The destination field index is instrWord[25:23]. A request sampled at a rising clock edge changes only that field, and the change is visible right after that edge.
- R9: A record request (`recValid`) compares `recResult` with zero, signed, and writes field 0, leaving fields 1 to 7 alone. The compare is narrowed to 32 bits when `wideMode` is 0.
- R10: When an explicit compare targets field 0 in the same cycle as a record request, field 0 takes the explicit result. When the targets differ, both fields update.
- R11: An `issueValid` cycle whose opcode pair is not one of the four compares changes no field. A cycle with no valid request also changes no field.
- R12: After reset the condition register reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | An explicit compare instruction is presented |
| instrWord | input | 32 | Instruction word of the compare |
| opndA | input | 64 | First register operand |
| opndB | input | 64 | Second register operand (register-register forms) |
| wideMode | input | 1 | Core is in 64-bit mode |
| sumOvf | input | 1 | Summary-overflow bit of the fixed-point exception register |
| recValid | input | 1 | A record-form result is presented |
| recResult | input | 64 | Arithmetic result to compare against zero |
| condReg | output | 32 | The eight-field condition register |

## Verification
The hardest situations to reach are the ones where the narrowed compare and the full-width compare disagree. In these cases the upper 32 bits of an operand point the other way from the sign of the low word. The stimulus builds such operand pairs and runs each one with the width bit cleared, and also with `wideMode` low while the bit is set. The other hard case is the collision on field 0. Directed cycles raise `recValid` together with an explicit compare, once aimed at field 0 and once at another field. The bench then reads both fields back from `condReg`.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  localparam int FIELDS   = 8;
  localparam int FIELD_W  = 4;
  localparam int FIDX_W   = $clog2(FIELDS);

  localparam logic [5:0] OPC_XFORM = 6'd31;
  localparam logic [5:0] OPC_IMM_S = 6'd11;
  localparam logic [5:0] OPC_IMM_U = 6'd10;
  localparam logic [9:0] XO_CMP_S  = 10'd0;
  localparam logic [9:0] XO_CMP_U  = 10'd32;

  // Strobes from the decoder to the datapath.
  typedef struct packed {
    logic              cmpEn;
    logic              isSigned;
    logic              useImm;
    logic              fullWidth;
    logic [FIDX_W-1:0] dstField;
    logic              recEn;
    logic              recFull;
  } ccu_ctrl_t;

endpackage

// File: rtl/ccu_magcmp.sv
module ccu_magcmp #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             isSigned,
  output logic             lt,
  output logic             gt,
  output logic             eq
);
  logic [WIDTH-1:0] aBias;
  logic [WIDTH-1:0] bBias;

  // Flipping the sign bit maps two's-complement order onto unsigned order.
  always_comb begin
    aBias = {a[WIDTH-1] ^ isSigned, a[WIDTH-2:0]};
    bBias = {b[WIDTH-1] ^ isSigned, b[WIDTH-2:0]};
    lt    = aBias < bBias;
    gt    = aBias > bBias;
    eq    = !lt && !gt;
  end
endmodule

// File: rtl/ccu_ctrl.sv
module ccu_ctrl
  import ccu_pkg::*;
(
  input  logic        issueValid,
  input  logic [31:0] instrWord,
  input  logic        wideMode,
  input  logic        recValid,
  output ccu_ctrl_t   ctrl
);
  logic [5:0] primOp;
  logic [9:0] extOp;
  logic       widthBit;
  logic       isRegSigned;
  logic       isRegUnsigned;
  logic       isImmSigned;
  logic       isImmUnsigned;

  always_comb begin
    primOp        = instrWord[31:26];
    extOp         = instrWord[10:1];
    widthBit      = instrWord[21];
    isRegSigned   = (primOp == OPC_XFORM) && (extOp == XO_CMP_S);
    isRegUnsigned = (primOp == OPC_XFORM) && (extOp == XO_CMP_U);
    isImmSigned   = (primOp == OPC_IMM_S);
    isImmUnsigned = (primOp == OPC_IMM_U);

    ctrl.cmpEn     = issueValid &&
                     (isRegSigned || isRegUnsigned || isImmSigned || isImmUnsigned);
    ctrl.isSigned  = isRegSigned || isImmSigned;
    ctrl.useImm    = isImmSigned || isImmUnsigned;
    ctrl.fullWidth = wideMode && widthBit;
    ctrl.dstField  = instrWord[25:23];
    ctrl.recEn     = recValid;
    ctrl.recFull   = wideMode;
  end
endmodule

// File: rtl/ccu_datapath.sv
module ccu_datapath
  import ccu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32,
  parameter int IMMW   = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ccu_ctrl_t                 ctrl,
  input  logic [XLEN-1:0]           opndA,
  input  logic [XLEN-1:0]           opndB,
  input  logic [IMMW-1:0]           imm,
  input  logic                      sumOvf,
  input  logic [XLEN-1:0]           recResult,
  output logic [FIELDS*FIELD_W-1:0] condReg
);
  localparam int CRW  = FIELDS * FIELD_W;
  localparam int UPPR = XLEN - NARROW;
  localparam int IMMX = XLEN - IMMW;

  logic [XLEN-1:0]  immExt;
  logic [XLEN-1:0]  bSel;
  logic [XLEN-1:0]  aCmp;
  logic [XLEN-1:0]  bCmp;
  logic [XLEN-1:0]  recCmp;
  logic             cLt, cGt, cEq;
  logic             rLt, rGt, rEq;
  logic [FIELD_W-1:0] cmpCode;
  logic [FIELD_W-1:0] recCode;
  logic [CRW-1:0]   crNext;

  always_comb begin
    immExt = ctrl.isSigned ? {{IMMX{imm[IMMW-1]}}, imm} : {{IMMX{1'b0}}, imm};
    bSel   = ctrl.useImm ? immExt : opndB;
    if (ctrl.fullWidth) begin
      aCmp = opndA;
      bCmp = bSel;
    end else begin
      aCmp = {{UPPR{ctrl.isSigned & opndA[NARROW-1]}}, opndA[NARROW-1:0]};
      bCmp = {{UPPR{ctrl.isSigned & bSel[NARROW-1]}}, bSel[NARROW-1:0]};
    end
    recCmp = ctrl.recFull ? recResult
                          : {{UPPR{recResult[NARROW-1]}}, recResult[NARROW-1:0]};
  end

  ccu_magcmp #(.WIDTH(XLEN)) explicitCmp_i (
    .a(aCmp), .b(bCmp), .isSigned(ctrl.isSigned),
    .lt(cLt), .gt(cGt), .eq(cEq)
  );

  ccu_magcmp #(.WIDTH(XLEN)) recordCmp_i (
    .a(recCmp), .b('0), .isSigned(1'b1),
    .lt(rLt), .gt(rGt), .eq(rEq)
  );

  always_comb begin
    cmpCode = {cLt, cGt, cEq, sumOvf};
    recCode = {rLt, rGt, rEq, sumOvf};
    crNext  = condReg;
    if (ctrl.recEn)
      crNext[CRW-1 -: FIELD_W] = recCode;
    // Explicit compare is applied last, so it overrides a record write to field 0.
    if (ctrl.cmpEn)
      crNext[CRW-1-FIELD_W*int'(ctrl.dstField) -: FIELD_W] = cmpCode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) condReg <= '0;
    else        condReg <= crNext;
  end
endmodule

// File: rtl/ccu_top.sv
module ccu_top
  import ccu_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int NARROW = 32,
  parameter int IMMW   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issueValid,
  input  logic [31:0]     instrWord,
  input  logic [XLEN-1:0] opndA,
  input  logic [XLEN-1:0] opndB,
  input  logic            wideMode,
  input  logic            sumOvf,
  input  logic            recValid,
  input  logic [XLEN-1:0] recResult,
  output logic [31:0]     condReg
);
  ccu_ctrl_t ctrl;

  ccu_ctrl ctrl_i (
    .issueValid(issueValid), .instrWord(instrWord), .wideMode(wideMode),
    .recValid(recValid), .ctrl(ctrl)
  );

  ccu_datapath #(.XLEN(XLEN), .NARROW(NARROW), .IMMW(IMMW)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .opndA(opndA), .opndB(opndB),
    .imm(instrWord[IMMW-1:0]), .sumOvf(sumOvf), .recResult(recResult),
    .condReg(condReg)
  );
endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issueValid,
  input logic            recValid,
  input logic            sumOvf,
  input logic [XLEN-1:0] recResult,
  input logic [31:0]     condReg
);
  for (genvar k = 0; k < 8; k++) begin : g_field
    assert_onehot_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(condReg[4*k+1 +: 3]) <= 1);
  end

  assert_idle_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!issueValid && !recValid) |=> $stable(condReg));

  assert_rec_only_field0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (recValid && !issueValid) |=> $stable(condReg[27:0]));

  assert_rec_zero_eq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (recValid && !issueValid && recResult == '0) |=> condReg[31:29] == 3'b001);

  assert_rec_so_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (recValid && !issueValid) |=> condReg[28] == $past(sumOvf));

  assert_reset_clear_R12: assert property (@(posedge clk)
    !rst_n |=> condReg == '0);
endmodule

bind ccu_top ccu_checker #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .recValid(recValid),
  .sumOvf(sumOvf), .recResult(recResult), .condReg(condReg)
);

// File: tb/ccu_top_tb.sv
module ccu_top_tb_top;
  localparam int PERIOD = 10;
  localparam int NVEC   = 12;

  typedef struct packed {
    logic [1:0]  kind;   // 0 reg signed, 1 reg unsigned, 2 imm signed, 3 imm unsigned
    logic [2:0]  crf;
    logic        lBit;
    logic        wide;
    logic        so;
    logic [63:0] a;
    logic [63:0] b;      // low 16 bits are the immediate for kinds 2 and 3
    logic [3:0]  exp;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 3'd1, 1'b1, 1'b1, 1'b0, 64'd5, 64'd7, 4'b1000},
    '{2'd0, 3'd2, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'b1001},
    '{2'd1, 3'd3, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'b0100},
    '{2'd0, 3'd4, 1'b0, 1'b1, 1'b0, 64'h0000_0001_8000_0000, 64'd0, 4'b1000},
    '{2'd1, 3'd5, 1'b0, 1'b1, 1'b1, 64'hFFFF_FFFF_0000_0005, 64'd5, 4'b0011},
    '{2'd0, 3'd6, 1'b1, 1'b0, 1'b0, 64'h0000_0001_0000_0000, 64'd0, 4'b0010},
    '{2'd2, 3'd7, 1'b1, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0000_0000_FFFE, 4'b1000},
    '{2'd3, 3'd0, 1'b1, 1'b1, 1'b0, 64'd3, 64'h0000_0000_0000_FFFE, 4'b1000},
    '{2'd2, 3'd1, 1'b1, 1'b1, 1'b0, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_8000, 4'b0100},
    '{2'd1, 3'd2, 1'b1, 1'b1, 1'b1, 64'd7, 64'd7, 4'b0011},
    '{2'd0, 3'd7, 1'b0, 1'b1, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 4'b0100},
    '{2'd3, 3'd3, 1'b0, 1'b0, 1'b0, 64'hABCD_0000_0000_0010, 64'h0000_0000_0000_0010, 4'b0010}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issueValid;
  logic [31:0] instrWord;
  logic [63:0] opndA;
  logic [63:0] opndB;
  logic        wideMode;
  logic        sumOvf;
  logic        recValid;
  logic [63:0] recResult;
  logic [31:0] condReg;

  int  nChecks = 0;
  int  nFails  = 0;
  logic [31:0] model;

  always #(PERIOD/2) clk = ~clk;

  ccu_top dut_i (
    .clk(clk), .rst_n(rst_n), .issueValid(issueValid), .instrWord(instrWord),
    .opndA(opndA), .opndB(opndB), .wideMode(wideMode), .sumOvf(sumOvf),
    .recValid(recValid), .recResult(recResult), .condReg(condReg)
  );

  function automatic logic [31:0] mkInstr(logic [1:0] kind, logic [2:0] crf,
                                          logic l, logic [15:0] imm);
    case (kind)
      2'd0:    return {6'd31, crf, 1'b0, l, 10'd0, 10'd0, 1'b0};
      2'd1:    return {6'd31, crf, 1'b0, l, 10'd0, 10'd32, 1'b0};
      2'd2:    return {6'd11, crf, 1'b0, l, 5'd0, imm};
      default: return {6'd10, crf, 1'b0, l, 5'd0, imm};
    endcase
  endfunction

  function automatic logic [31:0] putField(logic [31:0] cr, int idx, logic [3:0] code);
    logic [31:0] r = cr;
    r[31-4*idx -: 4] = code;
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: condReg actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    issueValid = 1'b0; instrWord = '0; opndA = '0; opndB = '0;
    wideMode = 1'b1; sumOvf = 1'b0; recValid = 1'b0; recResult = '0;
  endtask

  // Inputs are driven at a falling edge, sampled at the next rising edge,
  // and the result is read at the following falling edge.
  task automatic stepCycle();
    @(negedge clk);
    idleInputs();
  endtask

  initial begin : watchdog
    #(PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    idleInputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    check("R12 reset", condReg, 32'h0);

    // Table walk: explicit compares (R1..R8).
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      issueValid = 1'b1;
      instrWord  = mkInstr(VECS[i].kind, VECS[i].crf, VECS[i].lBit, VECS[i].b[15:0]);
      opndA      = VECS[i].a;
      opndB      = VECS[i].b;
      wideMode   = VECS[i].wide;
      sumOvf     = VECS[i].so;
      stepCycle();
      model = putField(model, int'(VECS[i].crf), VECS[i].exp);
      check($sformatf("R1 R2 R3 R4 R5 R6 R7 R8 vector %0d", i), condReg, model);
    end

    // R11: unrecognised extended opcode under primary 31.
    @(negedge clk);
    issueValid = 1'b1; instrWord = {6'd31, 3'd1, 1'b0, 1'b1, 10'd0, 10'd1, 1'b0};
    opndA = 64'd100; opndB = 64'd1;
    stepCycle();
    check("R11 bad extended opcode", condReg, model);

    // R11: unrecognised primary opcode.
    @(negedge clk);
    issueValid = 1'b1; instrWord = mkInstr(2'd2, 3'd2, 1'b1, 16'h0005);
    instrWord[31:26] = 6'd12; opndA = 64'd100;
    stepCycle();
    check("R11 bad primary opcode", condReg, model);

    // R11: legal word without issueValid.
    @(negedge clk);
    instrWord = mkInstr(2'd0, 3'd3, 1'b1, 16'h0); opndA = 64'd1; opndB = 64'd9;
    stepCycle();
    check("R11 no valid", condReg, model);

    // R9: negative result in 64-bit mode, SO set.
    @(negedge clk);
    recValid = 1'b1; recResult = 64'hFFFF_FFFF_FFFF_FFFB; wideMode = 1'b1; sumOvf = 1'b1;
    stepCycle();
    model = putField(model, 0, 4'b1001);
    check("R9 R3 record negative", condReg, model);

    // R9: narrowed record result equals zero.
    @(negedge clk);
    recValid = 1'b1; recResult = 64'h0000_0001_0000_0000; wideMode = 1'b0;
    stepCycle();
    model = putField(model, 0, 4'b0010);
    check("R9 record narrowed", condReg, model);

    // R9: same result at full width is positive.
    @(negedge clk);
    recValid = 1'b1; recResult = 64'h0000_0001_0000_0000; wideMode = 1'b1;
    stepCycle();
    model = putField(model, 0, 4'b0100);
    check("R9 record full width", condReg, model);

    // R10: collision on field 0, explicit wins.
    @(negedge clk);
    issueValid = 1'b1; instrWord = mkInstr(2'd0, 3'd0, 1'b1, 16'h0);
    opndA = 64'd1; opndB = 64'd2;
    recValid = 1'b1; recResult = 64'd0;
    stepCycle();
    model = putField(model, 0, 4'b1000);
    check("R10 field 0 priority", condReg, model);

    // R10: different targets, both fields update.
    @(negedge clk);
    issueValid = 1'b1; instrWord = mkInstr(2'd1, 3'd5, 1'b1, 16'h0);
    opndA = 64'd9; opndB = 64'd2; sumOvf = 1'b1;
    recValid = 1'b1; recResult = 64'hFFFF_FFFF_FFFF_FFFF;
    stepCycle();
    model = putField(model, 5, 4'b0101);
    model = putField(model, 0, 4'b1001);
    check("R10 dual write", condReg, model);

    // R12: reset clears a populated register.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R12 reset again", condReg, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule